// File: doc/BRIEF.md
# Busy-Signalled SAR ADC Read Controller

This block is the host side of a link to a 14-bit successive-approximation converter that uses three wires: a convert strobe, a serial clock and a single data line with an external pull-up. A one-cycle start request raises the convert strobe, which begins a conversion. The converter then releases its data line, and the pull-up holds it high. After a fixed number of cycles the controller drops the strobe again and waits for the converter to pull the data line low. That falling transition marks the end of the conversion.

Once it sees the transition, the controller drives serial clock pulses. It captures one data bit for each falling clock edge, most significant bit first. It can send one extra pulse so that the converter releases the line. It then presents the assembled word together with a one-cycle valid strobe. If the end-of-conversion transition never arrives, a timeout strobe is raised and the controller returns to idle.

All timing values are parameters counted in system clock cycles: the strobe-high time, the earliest accepted end of conversion, the latest expected end, the timeout margin and the serial clock half-period.

Top module: `adc_busy_reader`

## Requirements
- R1: While reset is high and in the first cycle after it, `cnv_o`, `sck_o`, `valid_o` and `timeout_o` are all 0.
- R2: A start request accepted in idle drives `cnv_o` high for exactly CNV_HIGH cycles (default 4). It then stays low until the read ends or the timeout fires.
- R3: The data input passes through two synchroniser stages. The read begins only on a high-to-low transition of the synchronised line that is seen when at least CONV_MIN cycles (default 20) have passed since the start was accepted. Earlier transitions are ignored.
- R4: The read captures DATA_W bits (default 14) MSB first. Bit k is sampled at the end of the low phase that follows the k-th falling edge of `sck_o`. Each `sck_o` phase lasts SCK_HALF cycles (default 4), and each pulse begins with its high phase.
- R5: With EXTRA_EDGE=1 (the default), one more `sck_o` pulse follows the data pulses, for DATA_W+1 falling edges per read. With EXTRA_EDGE=0 there are exactly DATA_W falling edges.
- R6: After the last pulse, `sample_o` holds the captured word and `valid_o` is high for exactly one cycle, once per read.
- R7: If no accepted transition occurs, `timeout_o` pulses for one cycle exactly CONV_MAX+TO_MARGIN cycles (default 48) after the start was accepted. No `valid_o` follows, and the controller returns to idle.
- R8: Start requests that arrive while a conversion or read is in progress are ignored. They produce no further `cnv_o` rise and do not disturb the result.
- R9: `cnv_o` and `sck_o` are never high in the same cycle, and `sck_o` is low whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| sdo_i | input | 1 | Converter data line (pulled high when released) |
| cnv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sample_o | output | DATA_W | Last captured sample |
| valid_o | output | 1 | One-cycle strobe: `sample_o` is new |
| timeout_o | output | 1 | One-cycle strobe: no end of conversion seen |

## Verification
A wrong state register shows up within one clock. The convert strobe would be stretched or dropped early, or serial clock pulses would appear while the strobe is still high, and the cycle-by-cycle strobe and clock monitors catch both. A bad bit counter or capture point shows up when the read ends. The number of falling clock edges no longer matches DATA_W plus the extra pulse, or the delivered word is shifted against the converter model's word. A missing minimum-wait gate is exposed by an early glitch on the data line, which starts the read about twenty cycles too soon and corrupts every bit.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CNV_HI = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SHIFT  = 3'd3,
        ST_DONE   = 3'd4
    } rd_state_t;

    // width of a counter able to hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dsync,
    output logic dfall
);
    logic [2:0] stg_q;

    // reset to the released (pulled-up) level
    always_ff @(posedge clk) begin
        if (rst) stg_q <= 3'b111;
        else     stg_q <= {stg_q[1:0], din};
    end

    assign dsync = stg_q[1];
    assign dfall = stg_q[2] & ~stg_q[1];
endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
    parameter int DATA_W     = 14,
    parameter int SCK_HALF   = 4,
    parameter int EXTRA_EDGE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic sck,
    output logic cap_stb,
    output logic done_stb
);
    import adc_rd_pkg::*;

    localparam int NPULSE = DATA_W + ((EXTRA_EDGE != 0) ? 1 : 0);
    localparam int PW     = cnt_w(SCK_HALF);
    localparam int BW     = cnt_w(NPULSE);

    logic          active_q;
    logic [PW-1:0] phase_q;
    logic [BW-1:0] pulse_q;
    logic          low_end;

    assign low_end  = active_q && !sck && (phase_q == PW'(SCK_HALF - 1));
    assign cap_stb  = low_end && (pulse_q < BW'(DATA_W));
    assign done_stb = low_end && (pulse_q == BW'(NPULSE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sck      <= 1'b0;
            phase_q  <= '0;
            pulse_q  <= '0;
        end else if (go && !active_q) begin
            active_q <= 1'b1;
            sck      <= 1'b1;
            phase_q  <= '0;
            pulse_q  <= '0;
        end else if (active_q) begin
            if (phase_q == PW'(SCK_HALF - 1)) begin
                phase_q <= '0;
                if (sck) begin
                    sck <= 1'b0;
                end else if (pulse_q == BW'(NPULSE - 1)) begin
                    active_q <= 1'b0;
                end else begin
                    sck     <= 1'b1;
                    pulse_q <= pulse_q + 1'b1;
                end
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // R4: a clock phase never ends before SCK_HALF cycles
    a_r4_phase_len: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q) && $changed(sck)) |-> $past(phase_q) == PW'(SCK_HALF - 1));
endmodule

// File: rtl/adc_busy_reader.sv
module adc_busy_reader #(
    parameter int DATA_W     = 14,
    parameter int CNV_HIGH   = 4,
    parameter int CONV_MIN   = 20,
    parameter int CONV_MAX   = 40,
    parameter int TO_MARGIN  = 8,
    parameter int SCK_HALF   = 4,
    parameter int EXTRA_EDGE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              valid_o,
    output logic              timeout_o
);
    import adc_rd_pkg::*;

    localparam int LIMIT = CONV_MAX + TO_MARGIN;
    localparam int TW    = cnt_w(LIMIT);

    rd_state_t         state_q;
    logic [TW-1:0]     tcnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              sdo_s, sdo_fall;
    logic              accept, go;
    logic              cap_stb, done_stb;

    adc_rd_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (sdo_i),
        .dsync (sdo_s),
        .dfall (sdo_fall)
    );

    assign accept = (state_q == ST_WAIT) && sdo_fall && (tcnt_q >= TW'(CONV_MIN));
    assign go     = accept;

    adc_rd_sclk #(
        .DATA_W     (DATA_W),
        .SCK_HALF   (SCK_HALF),
        .EXTRA_EDGE (EXTRA_EDGE)
    ) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .sck      (sck_o),
        .cap_stb  (cap_stb),
        .done_stb (done_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tcnt_q    <= '0;
            cnv_o     <= 1'b0;
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
            sample_o  <= '0;
            shreg_q   <= '0;
        end else begin
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
            if (cap_stb) shreg_q <= {shreg_q[DATA_W-2:0], sdo_s};
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_CNV_HI;
                        tcnt_q  <= '0;
                        cnv_o   <= 1'b1;
                    end
                end
                ST_CNV_HI: begin
                    tcnt_q <= tcnt_q + 1'b1;
                    if (tcnt_q == TW'(CNV_HIGH - 1)) begin
                        cnv_o   <= 1'b0;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    tcnt_q <= tcnt_q + 1'b1;
                    if (accept) begin
                        state_q <= ST_SHIFT;
                    end else if (tcnt_q == TW'(LIMIT - 1)) begin
                        timeout_o <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_SHIFT: begin
                    if (done_stb) state_q <= ST_DONE;
                end
                ST_DONE: begin
                    sample_o <= shreg_q;
                    valid_o  <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r9_cnv_sck_excl: assert property (@(posedge clk) disable iff (rst)
        !(cnv_o && sck_o));
    a_r2_cnv_low_wait: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT || state_q == ST_SHIFT) |-> !cnv_o);
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    a_r7_timeout_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> (!timeout_o && !valid_o && !cnv_o));
    a_r3_min_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_o) && $past(state_q) == ST_WAIT |-> $past(tcnt_q) >= TW'(CONV_MIN));
    a_r9_sck_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !sck_o);
endmodule

// File: tb/test_adc_busy_reader.sv
module test_adc_busy_reader;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         sdo_i;
    logic         cnv_o, sck_o, valid_o, timeout_o;
    logic [W-1:0] sample_o;

    always #5 clk = ~clk;

    adc_busy_reader i_adc_busy_reader (
        .clk(clk), .rst(rst), .start_i(start_i), .sdo_i(sdo_i),
        .cnv_o(cnv_o), .sck_o(sck_o), .sample_o(sample_o),
        .valid_o(valid_o), .timeout_o(timeout_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // converter model state
    logic [W-1:0] adc_word = '0;
    bit adc_mute = 0, adc_glitch = 0;
    int adc_conv_t = 30;
    bit busy = 0, rd = 0, hiz = 1, drv = 0, pcnv = 0, psck = 0;
    int cc = 0, bi = 0;

    // observation counters
    int cnv_rises = 0, cnv_width = 0, cnv_run = 0, sck_falls = 0;
    int valid_cnt = 0, to_cnt = 0, rise_cyc = 0, to_cyc = 0;
    logic [W-1:0] got = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    assign sdo_i = hiz ? !(adc_glitch && busy && cc >= 5 && cc < 8) : drv;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            // R9 checked every cycle
            chk(!(cnv_o && sck_o), "R9 cnv/sck overlap", int'(sck_o), 0);
            if (cnv_o && !pcnv) begin cnv_rises++; rise_cyc = cyc; cnv_run = 0; end
            if (cnv_o) cnv_run++;
            if (!cnv_o && pcnv) cnv_width = cnv_run;
            if (psck && !sck_o) sck_falls++;
            if (valid_o) begin valid_cnt++; got = sample_o; end
            if (timeout_o) begin to_cnt++; to_cyc = cyc; end
        end
        if (cnv_o && !pcnv) begin
            busy = 1; cc = 0; hiz = 1; rd = 0; bi = 0;
        end else if (busy) begin
            cc++;
            if (!adc_mute && cc >= adc_conv_t && !cnv_o) begin
                busy = 0; rd = 1; hiz = 0; drv = 0;
            end
        end
        if (rd && psck && !sck_o) begin
            bi++;
            if (bi <= W) drv = adc_word[W-bi];
            else begin hiz = 1; rd = 0; end
        end
        pcnv = cnv_o;
        psck = sck_o;
    end

    task automatic run(input logic [W-1:0] word, input bit mute, input bit glitch, input bit restart);
        adc_word = word; adc_mute = mute; adc_glitch = glitch;
        cnv_rises = 0; cnv_width = 0; sck_falls = 0; valid_cnt = 0; to_cnt = 0;
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        for (int n = 0; n < 400; n++) begin
            @(posedge clk); #1;
            start_i = restart && (n == 25 || n == 70);
            if (valid_cnt != 0 || to_cnt != 0) break;
        end
        start_i = 1'b0;
        repeat (20) @(posedge clk);
        #1;
    endtask

    task automatic check_read(input logic [W-1:0] word, input string tag);
        chk(got == word, {tag, " R4 word"}, int'(got), int'(word));
        chk(valid_cnt == 1, "R6 valid count", valid_cnt, 1);
        chk(cnv_width == 4, "R2 cnv width", cnv_width, 4);
        chk(sck_falls == W + 1, "R5 sck falls", sck_falls, W + 1);
        chk(to_cnt == 0, "R7 no timeout", to_cnt, 0);
        chk(cnv_rises == 1, "R8 single conversion", cnv_rises, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        chk(!cnv_o && !sck_o && !valid_o && !timeout_o, "R1 reset outputs", int'({cnv_o, sck_o, valid_o, timeout_o}), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(!cnv_o && !sck_o && !valid_o && !timeout_o, "R1 after reset", int'({cnv_o, sck_o, valid_o, timeout_o}), 0);

        run(14'h3FFF, 0, 0, 0); check_read(14'h3FFF, "all ones");
        run(14'h0000, 0, 0, 0); check_read(14'h0000, "all zeros");
        run(14'h2A5B, 0, 0, 0); check_read(14'h2A5B, "pattern");
        // R3: early glitch on the data line must be ignored
        run(14'h1234, 0, 1, 0); check_read(14'h1234, "R3 glitch");
        // R8: extra start requests during wait and shift
        run(14'h2001, 0, 0, 1); check_read(14'h2001, "R8 restart");
        // R7: converter never signals completion
        run(14'h0155, 1, 0, 0);
        chk(to_cnt == 1, "R7 timeout count", to_cnt, 1);
        chk(to_cyc - rise_cyc == 48, "R7 timeout delay", to_cyc - rise_cyc, 48);
        chk(valid_cnt == 0, "R7 no valid", valid_cnt, 0);
        chk(!cnv_o && !sck_o, "R7 back to idle", int'({cnv_o, sck_o}), 0);
        // recovery after timeout
        run(14'h0ABC, 0, 0, 0); check_read(14'h0ABC, "after timeout");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule